// File: doc/BRIEF.md
# Serial Configuration Write Port

This block is a write-only three-wire serial slave that loads a small set of control registers for a multi-channel serialising output stage. A host lowers an active-low select line and clocks eight data bits into the port. Each bit is sampled on the rising serial-clock edge, most significant bit first. The upper nibble of the frame names a register and the lower nibble is the value to write.

The port runs directly on the serial clock, which may be as fast as 20 MHz, and does not oversample it. When the select line is released, a complete frame is handed to the sample-clock domain and written into the register file. From there the registers drive the output stage. This stage has:

- a test-pattern selector;
- a data-lane drive-current code;
- a clock-lane current doubler;
- a bit-order selector;
- eight per-channel power-down bits;
- three nibbles that form a 12-bit custom pattern.

An active-low reset restores every register to zero.

Top module: `cfgp_port`

## Requirements
- R1: While `rst_n` is low, and after it is released with no frame written, every output is zero (normal pattern, current code 00, no doubling, LSB first, all channels powered up, custom pattern 0).
- R2: A frame is the bits sampled on rising `sclk` edges while `csn` is low. They are taken MSB first. Bits 7..4 are the register address and bits 3..0 are the data.
- R3: A valid frame changes no output at or before the second rising `clk` edge after `csn` rises. The new value is visible after the third rising `clk` edge.
- R4: Address 0 sets the pattern code from data bits 3..2 and the data-lane current code from bits 1..0. Pattern codes: 00 normal, 01 deskew, 10 sync, 11 custom.
- R5: Address 1 sets `clk_cur_dbl` from data bit 0 and `msb_first` from data bit 2. Data bits 1 and 3 have no effect.
- R6: Address 2 writes `chan_pd[3:0]` with data bit 0 going to channel 0. Address 3 writes `chan_pd[7:4]` with data bit 0 going to channel 4.
- R7: Addresses 4, 5 and 6 write `cust_pat[3:0]`, `cust_pat[7:4]` and `cust_pat[11:8]` respectively.
- R8: A frame with fewer than 8 bits when `csn` rises changes no output.
- R9: A frame with more than 8 bits changes no output.
- R10: A write to any address from 7 to 15 changes no output.
- R11: A write changes only the fields of the addressed register. All other outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| csn | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial data, sampled on rising `sclk` |
| pat_sel | output | 2 | Test pattern code |
| lane_cur | output | 2 | Data-lane drive-current code |
| clk_cur_dbl | output | 1 | Doubles clock-lane current when 1 |
| msb_first | output | 1 | Serialise MSB first when 1, LSB first when 0 |
| chan_pd | output | 8 | Per-channel power-down, bit n is channel n |
| cust_pat | output | 12 | Custom pattern assembled from three nibbles |

## Verification
Every result is tied to the rise of `csn`. The bench releases `csn` one nanosecond after a falling `clk` edge, so the event cannot land on a rising edge. For each frame, the monitor first waits for two rising `clk` edges and samples between edges; at that point it expects the previous register state. It then waits for a third rising edge and expects the new state. Frames that must be discarded or ignored are checked the same way, with the expected state left equal to the previous one. Every check compares the whole register set, so a write that disturbs another field is also caught.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int CP_NUM_CH  = 8;   // power-down channels
    localparam int CP_NIB     = 4;   // address and data width
    localparam int CP_CUST_N  = 3;   // custom-pattern nibbles
    localparam int CP_FRAME_W = 2 * CP_NIB;

    localparam int CP_PD_REGS    = CP_NUM_CH / CP_NIB;
    localparam int CP_A_MODE     = 0;
    localparam int CP_A_CLK      = 1;
    localparam int CP_A_PD_BASE  = 2;
    localparam int CP_A_CUS_BASE = CP_A_PD_BASE + CP_PD_REGS;
    localparam int CP_A_LAST     = CP_A_CUS_BASE + CP_CUST_N - 1;

    typedef struct packed {
        logic [1:0]                  pat;
        logic [1:0]                  cur;
        logic                        clk_dbl;
        logic                        msb_first;
        logic [CP_NUM_CH-1:0]        pd;
        logic [CP_CUST_N*CP_NIB-1:0] cust;
    } cfg_regs_t;
endpackage

// File: rtl/cfgp_shift_rx.sv
module cfgp_shift_rx
    import cfgp_pkg::*;
(
    input  logic                  sclk,
    input  logic                  rst_n,
    input  logic                  csn,
    input  logic                  sdi,
    output logic [CP_FRAME_W-1:0] word,
    output logic                  frame_ok
);
    localparam int CNT_SAT = CP_FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_SAT + 1);

    typedef struct packed {
        logic [CP_FRAME_W-1:0] sh;
        logic [CNT_W-1:0]      cnt;
    } rx_t;

    rx_t  rx_d, rx_q;
    logic fresh_q;
    logic fresh_set;

    // fresh marks that the next sampled bit opens a new frame
    assign fresh_set = csn | ~rst_n;

    always_ff @(posedge sclk or posedge fresh_set) begin
        if (fresh_set) fresh_q <= 1'b1;
        else           fresh_q <= 1'b0;
    end

    always_comb begin
        rx_d = rx_q;
        if (!csn) begin
            rx_d.sh = {rx_q.sh[CP_FRAME_W-2:0], sdi};
            if (fresh_q)
                rx_d.cnt = CNT_W'(1);
            else if (rx_q.cnt != CNT_W'(CNT_SAT))
                rx_d.cnt = rx_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign word     = rx_q.sh;
    assign frame_ok = (rx_q.cnt == CNT_W'(CP_FRAME_W));
endmodule

// File: rtl/cfgp_cdc_commit.sv
module cfgp_cdc_commit #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csn,
    output logic apply
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[DEPTH-2:0], csn};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    // rising edge of the synchronised select
    assign apply = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  apply,
    input  logic                  frame_ok,
    input  logic [CP_FRAME_W-1:0] word,
    output cfg_regs_t             regs
);
    cfg_regs_t regs_d, regs_q;
    logic [CP_NIB-1:0] addr, dat;

    assign addr = word[CP_FRAME_W-1:CP_NIB];
    assign dat  = word[CP_NIB-1:0];

    always_comb begin
        regs_d = regs_q;
        if (apply && frame_ok) begin
            if (addr == CP_NIB'(CP_A_MODE)) begin
                regs_d.pat = dat[3:2];
                regs_d.cur = dat[1:0];
            end
            if (addr == CP_NIB'(CP_A_CLK)) begin
                regs_d.clk_dbl   = dat[0];
                regs_d.msb_first = dat[2];
            end
            for (int g = 0; g < CP_PD_REGS; g++) begin
                if (addr == CP_NIB'(CP_A_PD_BASE + g))
                    regs_d.pd[g*CP_NIB +: CP_NIB] = dat;
            end
            for (int c = 0; c < CP_CUST_N; c++) begin
                if (addr == CP_NIB'(CP_A_CUS_BASE + c))
                    regs_d.cust[c*CP_NIB +: CP_NIB] = dat;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        csn,
    input  logic                        sclk,
    input  logic                        sdi,
    output logic [1:0]                  pat_sel,
    output logic [1:0]                  lane_cur,
    output logic                        clk_cur_dbl,
    output logic                        msb_first,
    output logic [CP_NUM_CH-1:0]        chan_pd,
    output logic [CP_CUST_N*CP_NIB-1:0] cust_pat
);
    logic [CP_FRAME_W-1:0] word_w;
    logic                  frame_ok_w;
    logic                  apply_w;
    cfg_regs_t             regs_w;

    cfgp_shift_rx u_rx (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .csn     (csn),
        .sdi     (sdi),
        .word    (word_w),
        .frame_ok(frame_ok_w)
    );

    cfgp_cdc_commit #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
        .clk  (clk),
        .rst_n(rst_n),
        .csn  (csn),
        .apply(apply_w)
    );

    cfgp_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .apply   (apply_w),
        .frame_ok(frame_ok_w),
        .word    (word_w),
        .regs    (regs_w)
    );

    assign pat_sel     = regs_w.pat;
    assign lane_cur    = regs_w.cur;
    assign clk_cur_dbl = regs_w.clk_dbl;
    assign msb_first   = regs_w.msb_first;
    assign chan_pd     = regs_w.pd;
    assign cust_pat    = regs_w.cust;
endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk
    import cfgp_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  apply,
    input logic                  frame_ok,
    input logic [CP_FRAME_W-1:0] word,
    input cfg_regs_t             regs
);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(regs));

    // R8
    bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !frame_ok) |=> $stable(regs));

    // R10
    resv_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && frame_ok && (word[7:4] > 4'(CP_A_LAST))) |=> $stable(regs));

    // R4
    mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && frame_ok && word[7:4] == 4'd0) |=>
        (regs.pat == $past(word[3:2]) && regs.cur == $past(word[1:0])));

    // R6
    pd_low_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && frame_ok && word[7:4] == 4'd2) |=>
        (regs.pd[3:0] == $past(word[3:0]) && $stable(regs.pd[7:4])));
endmodule

bind cfgp_port cfgp_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .apply   (apply_w),
    .frame_ok(frame_ok_w),
    .word    (word_w),
    .regs    (regs_w)
);

// File: tb/tb_cfgp_port.sv
module tb_cfgp_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        csn = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [1:0]  pat_sel, lane_cur;
    logic        clk_cur_dbl, msb_first;
    logic [7:0]  chan_pd;
    logic [11:0] cust_pat;

    int checks = 0;
    int errors = 0;
    logic [25:0] model = '0;
    logic [25:0] exp_q[$];
    logic [25:0] old_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    cfgp_port dut (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .sdi(sdi),
        .pat_sel(pat_sel), .lane_cur(lane_cur), .clk_cur_dbl(clk_cur_dbl),
        .msb_first(msb_first), .chan_pd(chan_pd), .cust_pat(cust_pat)
    );

    function automatic logic [25:0] outs();
        return {pat_sel, lane_cur, clk_cur_dbl, msb_first, chan_pd, cust_pat};
    endfunction

    // layout [25:24] pattern, [23:22] current, [21] doubler, [20] order,
    // [19:12] power-down, [11:0] custom pattern
    function automatic logic [25:0] apply_write(logic [25:0] m, logic [7:0] b);
        logic [25:0] r = m;
        case (b[7:4])
            4'd0: begin r[25:24] = b[3:2]; r[23:22] = b[1:0]; end
            4'd1: begin r[21] = b[0]; r[20] = b[2]; end
            4'd2: r[15:12] = b[3:0];
            4'd3: r[19:16] = b[3:0];
            4'd4: r[3:0]   = b[3:0];
            4'd5: r[7:4]   = b[3:0];
            4'd6: r[11:8]  = b[3:0];
            default: ;
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [25:0] act, logic [25:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: shifts nbits, the first 8 from b, extras zero
    task automatic send(logic [7:0] b, int nbits, string tag);
        logic [25:0] nxt;
        @(negedge clk); #1;
        csn = 1'b0;
        #24;
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 8) ? b[7-i] : 1'b0;
            #24 sclk = 1'b1;
            #24 sclk = 1'b0;
        end
        nxt = (nbits == 8) ? apply_write(model, b) : model;
        old_q.push_back(model);
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
        model = nxt;
        #16 csn = 1'b1;
        #80;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge csn);
            if (exp_q.size() > 0) begin
                logic [25:0] e, o;
                string t;
                e = exp_q.pop_front();
                o = old_q.pop_front();
                t = tag_q.pop_front();
                repeat (2) @(posedge clk);
                #2 check({t, " R3 early"}, outs(), o);
                @(posedge clk);
                #2 check(t, outs(), e);
            end
        end
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2 rst_n = 1'b0;
        #20;
        check("R1 in reset", outs(), '0);
        rst_n = 1'b1;
        #40;
        check("R1 after release", outs(), '0);

        send(8'h09, 8, "R4 sync pattern current 01");
        send(8'h1F, 8, "R5 double and msb, bits 1/3 ignored");
        send(8'h10, 8, "R5 clear");
        send(8'h2A, 8, "R6 low channels");
        send(8'h35, 8, "R6 high channels");
        send(8'h4C, 8, "R7 nibble 0");
        send(8'h53, 8, "R7 nibble 1");
        send(8'h6E, 8, "R7 nibble 2");
        send(8'h0F, 8, "R4 custom pattern current 11 R11");
        send(8'h7F, 8, "R10 address 7");
        send(8'hF5, 8, "R10 address 15");
        send(8'h21, 5, "R8 short frame");
        send(8'h2F, 9, "R9 long frame");
        send(8'h20, 8, "R2 frame after discards");

        @(negedge clk);
        rst_n = 1'b0;
        model = '0;
        #20;
        check("R1 mid-run reset", outs(), '0);
        rst_n = 1'b1;
        #40;
        send(8'h06, 8, "R2 write after reset");
        send(8'h14, 8, "R5 msb only R11");

        #100;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule